// File: doc/BRIEF.md
# Lazily Backed Sparse Memory

This block answers reads and writes across a very wide address window while holding real storage for only a handful of 4096-byte pages. Each page number that has been written gets one slot from a small pool. A fully associative tag table maps the page number to that slot. A page with no slot reads as zero. The block is meant to stand in for large memories in test systems, where software touches only a few scattered pages.

A slot is bound to a page only when a write to an unmapped page carries nonzero data in the bytes it writes, a slot is free, and the capacity check passes. The capacity check is strict: the bytes already mapped plus one more page must stay below `MAX_BYTES`. A write that does not qualify is dropped without any signal. Each slot keeps one written flag per 8-byte word. These flags are cleared when the slot is bound, so a new page reads as zero without the whole page being wiped. Requests use one cycle each. A read returns its data with a valid pulse one cycle later. A request with an illegal size or a misaligned address raises an error pulse instead and is ignored.

Top module: `spm_sparse_mem`

## Requirements
- R1: A request address splits into a page number, `req_addr[ADDR_W-1:12]`, and a byte offset, `req_addr[11:0]`. Two pages that differ only in their upper page-number bits are kept apart.
- R2: A read of a page that has no slot returns zero on `rsp_rdata` and changes no state.
- R3: An accepted read is answered by `rsp_valid` high for exactly one cycle, in the cycle after the request. Writes never raise `rsp_valid`.
- R4: A write to an unmapped page binds a slot only if all of these hold: the bytes it writes are not all zero, a slot is free, and (pages mapped + 1) * 4096 < `MAX_BYTES`. Any other such write is dropped, and the page still reads as zero.
- R5: A newly bound page reads as zero in every byte except the bytes written by the write that bound it.
- R6: Byte order is little-endian. The byte at address A+i travels on data bits [8i+7:8i]. `req_size` gives the byte count (1, 2, 4 or 8). A write changes only its own bytes. A read returns its bytes in the low lanes, with the upper lanes zero.
- R7: A request whose `req_size` is not 1, 2, 4 or 8, or whose address is not a multiple of the size, gives a one-cycle `rsp_err` pulse in the next cycle. It gives no `rsp_valid` and changes no storage. Because of the alignment rule, no legal access crosses a word or a page.
- R8: Reset removes every page mapping, so every page reads as zero afterwards, and it leaves `rsp_valid` and `rsp_err` low.
- R9: Reset also returns the full capacity, so after reset the same number of pages can be bound again.
- R10: The count of mapped pages always equals the number of occupied slots and never exceeds the capacity limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_wdata | input | 64 | Write data, right-aligned: the first byte is in bits [7:0] |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Illegal request seen in the previous cycle |

## Verification
The delicate cycle is the one in which a slot is bound and the first write into the page also lands. The write has to fill the rest of its 8-byte word with zeros, because the word's written flag was just cleared and the old storage contents are stale. The bench provokes this by binding pages with single-byte and two-byte writes at offsets inside a word. It then reads the whole word, the neighbouring words and the far end of the page, and expects zeros everywhere except the written bytes. It also checks that later partial writes merge with the bytes already stored. The capacity boundary is exercised in the same way: a nonzero write that would bring the mapped size up to exactly `MAX_BYTES` must be refused, and the refusal must show up as zero reads of that page.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int unsigned PAGE_SHIFT     = 12;
  localparam int unsigned PAGE_BYTES     = 1 << PAGE_SHIFT;
  localparam int unsigned LANE_SHIFT     = 3;
  localparam int unsigned LANES          = 1 << LANE_SHIFT;
  localparam int unsigned DATA_W         = 8 * LANES;
  localparam int unsigned WORD_IDX_W     = PAGE_SHIFT - LANE_SHIFT;
  localparam int unsigned WORDS_PER_PAGE = 1 << WORD_IDX_W;
endpackage

// File: rtl/spm_access_decode.sv
module spm_access_decode
  import spm_pkg::*;
(
  input  logic [LANE_SHIFT-1:0] addr_lo,
  input  logic [3:0]            size,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  bad,
  output logic [LANES-1:0]      lane_en,
  output logic [DATA_W-1:0]     wdata_lanes,
  output logic                  wr_nonzero
);
  logic             size_ok;
  logic             misalign;
  logic [LANES-1:0] base_lanes;
  logic [DATA_W-1:0] masked;

  always_comb begin
    size_ok  = 1'b1;
    misalign = 1'b0;
    case (size)
      4'd1: misalign = 1'b0;
      4'd2: misalign = addr_lo[0];
      4'd4: misalign = |addr_lo[1:0];
      4'd8: misalign = |addr_lo;
      default: size_ok = 1'b0;
    endcase
    bad = !size_ok || misalign;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign base_lanes[g]        = (4'(g) < size);
    assign masked[8*g +: 8]     = base_lanes[g] ? wdata[8*g +: 8] : 8'h00;
  end

  assign wr_nonzero  = |masked;
  assign lane_en     = bad ? '0 : (base_lanes << addr_lo);
  assign wdata_lanes = masked << {addr_lo, 3'b000};
endmodule

// File: rtl/spm_page_lookup.sv
module spm_page_lookup #(
  parameter int unsigned PN_W        = 28,
  parameter int unsigned SLOTS       = 4,
  parameter int unsigned SLOT_W      = 2,
  parameter int unsigned ALLOC_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   look_pn,
  input  logic              want_alloc,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              alloc_fire,
  output logic [SLOT_W-1:0] alloc_slot
);
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'((ALLOC_LIMIT > SLOTS) ? SLOTS : ALLOC_LIMIT);

  logic [PN_W-1:0]  tag_q [SLOTS];
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [CNT_W-1:0] pages_q, pages_d;
  logic [SLOTS-1:0] match;
  logic             have_free;
  logic             cap_ok;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == look_pn);
  end

  always_comb begin
    hit_slot   = '0;
    alloc_slot = '0;
    have_free  = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i])  hit_slot = SLOT_W'(i);
      if (!vld_q[i]) begin
        alloc_slot = SLOT_W'(i);
        have_free  = 1'b1;
      end
    end
  end

  assign hit        = |match;
  assign cap_ok     = pages_q < LIM;
  assign alloc_fire = want_alloc && !hit && have_free && cap_ok;

  always_comb begin
    vld_d   = vld_q;
    pages_d = pages_q;
    if (alloc_fire) begin
      vld_d[alloc_slot] = 1'b1;
      pages_d           = pages_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      pages_q <= '0;
    end else if (alloc_fire) begin
      vld_q   <= vld_d;
      pages_q <= pages_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) tag_q[alloc_slot] <= look_pn;
  end

  assert_tag_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  assert_count_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(pages_q));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pages_q <= LIM);
  assert_alloc_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> pages_q == CNT_W'($past(pages_q) + 1'b1));
endmodule

// File: rtl/spm_sparse_mem.sv
module spm_sparse_mem
  import spm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_BYTES = 12288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int unsigned PN_W        = ADDR_W - PAGE_SHIFT;
  localparam int unsigned SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned SLOTS_P2    = 1 << SLOT_W;
  localparam int unsigned MEM_DEPTH   = SLOTS_P2 * WORDS_PER_PAGE;
  localparam int unsigned ALLOC_LIMIT = (MAX_BYTES == 0) ? 0 : (MAX_BYTES - 1) / PAGE_BYTES;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_q, rst_meta_q} <= 2'b00;
    else        {rst_n_q, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic              bad, wr_nonzero;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] wdata_lanes;

  spm_access_decode u_dec (
    .addr_lo     (req_addr[LANE_SHIFT-1:0]),
    .size        (req_size),
    .wdata       (req_wdata),
    .bad         (bad),
    .lane_en     (lane_en),
    .wdata_lanes (wdata_lanes),
    .wr_nonzero  (wr_nonzero)
  );

  logic wr_req, rd_req;
  assign wr_req = req_valid &&  req_we && !bad;
  assign rd_req = req_valid && !req_we && !bad;

  logic              hit, alloc_fire;
  logic [SLOT_W-1:0] hit_slot, alloc_slot;

  spm_page_lookup #(
    .PN_W(PN_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .ALLOC_LIMIT(ALLOC_LIMIT)
  ) u_lut (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .look_pn    (req_addr[ADDR_W-1:PAGE_SHIFT]),
    .want_alloc (wr_req && wr_nonzero),
    .hit        (hit),
    .hit_slot   (hit_slot),
    .alloc_fire (alloc_fire),
    .alloc_slot (alloc_slot)
  );

  logic [WORD_IDX_W-1:0]        word_idx;
  logic [SLOT_W-1:0]            slot_sel;
  logic [SLOT_W+WORD_IDX_W-1:0] mem_idx;
  logic                         word_seen;
  logic                         do_write;

  logic [DATA_W-1:0]         mem_q [MEM_DEPTH];
  logic [WORDS_PER_PAGE-1:0] seen_q [SLOTS_P2];
  logic [WORDS_PER_PAGE-1:0] seen_d [SLOTS_P2];

  assign word_idx  = req_addr[PAGE_SHIFT-1:LANE_SHIFT];
  assign slot_sel  = alloc_fire ? alloc_slot : hit_slot;
  assign mem_idx   = {slot_sel, word_idx};
  assign word_seen = !alloc_fire && seen_q[slot_sel][word_idx];
  assign do_write  = wr_req && (hit || alloc_fire);

  // a word never written before is filled whole, zeros outside the lanes
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (do_write && (lane_en[i] || !word_seen))
        mem_q[mem_idx][8*i +: 8] <= wdata_lanes[8*i +: 8];
    end
  end

  always_comb begin
    seen_d = seen_q;
    if (alloc_fire) seen_d[alloc_slot] = '0;
    if (do_write)   seen_d[slot_sel][word_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_write) seen_q <= seen_d;
  end

  // read path: one register stage
  logic                  rd_live;
  logic [DATA_W-1:0]     rd_word_q;
  logic [LANE_SHIFT-1:0] rd_off_q;
  logic [3:0]            rd_size_q;
  logic                  rsp_valid_q, rsp_valid_d;
  logic                  rsp_err_q, rsp_err_d;

  assign rd_live = hit && seen_q[hit_slot][word_idx];

  always_ff @(posedge clk) begin
    if (rd_req) begin
      rd_word_q <= rd_live ? mem_q[mem_idx] : '0;
      rd_off_q  <= req_addr[LANE_SHIFT-1:0];
      rd_size_q <= req_size;
    end
  end

  always_comb begin
    rsp_valid_d = rd_req;
    rsp_err_d   = req_valid && bad;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  logic [DATA_W-1:0] rd_shift;
  logic [DATA_W-1:0] rd_mask;
  assign rd_shift = rd_word_q >> {rd_off_q, 3'b000};
  for (genvar g = 0; g < LANES; g++) begin : g_rmask
    assign rd_mask[8*g +: 8] = (4'(g) < rd_size_q) ? 8'hFF : 8'h00;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rd_shift & rd_mask;

  assert_read_answer_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    (req_valid && !req_we && !bad) |=> rsp_valid);
  assert_write_silent_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    (req_valid && req_we) |=> !rsp_valid);
  assert_err_resp_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    (req_valid && bad) |=> (rsp_err && !rsp_valid));
  assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    (req_valid && !bad) |-> ($countones(lane_en) == int'(req_size)));
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(rsp_valid && rsp_err));
endmodule

// File: tb/tb_spm_sparse_mem.sv
module tb_spm_sparse_mem;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [39:0] req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic        got_v, got_e;
  logic [63:0] got_d;

  localparam logic [39:0] PG_A = 40'h00_0000_0000;
  localparam logic [39:0] PG_B = 40'hFF_FFFF_F000;
  localparam logic [39:0] PG_C = 40'h00_0000_1000;

  always #4 clk = ~clk;

  spm_sparse_mem #(.ADDR_W(40), .SLOTS(4), .MAX_BYTES(12288)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [39:0] a, input logic [3:0] sz, input logic [63:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    got_v = rsp_valid; got_e = rsp_err; got_d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [39:0] a, input logic [3:0] sz, input logic [63:0] exp, input string tag);
    xfer(1'b0, a, sz, 64'h0);
    chk({tag, " valid"}, {63'h0, got_v}, 64'h1);
    chk(tag, got_d, exp);
  endtask

  task automatic wr(input logic [39:0] a, input logic [3:0] sz, input logic [63:0] d, input string tag);
    xfer(1'b1, a, sz, d);
    chk({tag, " no valid on write"}, {63'h0, got_v}, 64'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_size = 4'd1; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R8 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    chk("R8 rsp_err after reset", {63'h0, rsp_err}, 64'h0);
    rd(PG_A + 40'h10, 4'd8, 64'h0, "R2 unbacked read");
    rd(PG_B + 40'h10, 4'd8, 64'h0, "R3 read answered next cycle");
  endtask

  task automatic t_dropped_writes();
    wr(PG_A + 40'h10, 4'd8, 64'h0, "R4 zero write");
    rd(PG_A + 40'h10, 4'd8, 64'h0, "R4 zero write leaves page empty");
    wr(PG_A + 40'h13, 4'd1, 64'hFF00, "R4 nonzero only outside size");
    rd(PG_A + 40'h10, 4'd8, 64'h0, "R4 masked zero write dropped");
  endtask

  task automatic t_alloc_zero_fill();
    wr(PG_A + 40'h13, 4'd1, 64'h77AB, "R5 binding write");
    rd(PG_A + 40'h10, 4'd8, 64'h0000_0000_AB00_0000, "R5 written word zero elsewhere");
    rd(PG_A + 40'h18, 4'd8, 64'h0, "R5 next word zero");
    rd(PG_A + 40'hFF8, 4'd8, 64'h0, "R5 last word zero");
  endtask

  task automatic t_lanes();
    wr(PG_A + 40'h16, 4'd2, 64'h1234, "R6 halfword write");
    rd(PG_A + 40'h10, 4'd8, 64'h1234_0000_AB00_0000, "R6 merge keeps bytes");
    rd(PG_A + 40'h14, 4'd4, 64'h1234_0000, "R6 word read upper half");
    rd(PG_A + 40'h13, 4'd1, 64'hAB, "R6 byte read");
    rd(PG_A + 40'h12, 4'd2, 64'hAB00, "R6 halfword read");
    wr(PG_A + 40'h20, 4'd8, 64'h1122_3344_5566_7788, "R6 dword write");
    rd(PG_A + 40'h24, 4'd4, 64'h1122_3344, "R6 little endian upper");
    rd(PG_A + 40'h20, 4'd1, 64'h88, "R6 little endian lowest byte");
    wr(PG_A + 40'h20, 4'd1, 64'h0, "R6 zero byte to mapped page");
    rd(PG_A + 40'h20, 4'd8, 64'h1122_3344_5566_7700, "R6 zero byte written");
  endtask

  task automatic t_alias_and_capacity();
    wr(PG_B + 40'h10, 4'd8, 64'hCAFE, "R1 top page write");
    rd(PG_B + 40'h10, 4'd8, 64'hCAFE, "R1 top page read");
    rd(PG_A + 40'h10, 4'd8, 64'h1234_0000_AB00_0000, "R1 low page untouched");
    wr(PG_C + 40'h0, 4'd8, 64'h5, "R4 strict limit write");
    rd(PG_C + 40'h0, 4'd8, 64'h0, "R4 page past capacity reads zero");
    rd(PG_B + 40'h10, 4'd8, 64'hCAFE, "R4 mapped page still held");
  endtask

  task automatic t_errors();
    xfer(1'b0, PG_A + 40'h10, 4'd3, 64'h0);
    chk("R7 size 3 err", {63'h0, got_e}, 64'h1);
    chk("R7 size 3 no valid", {63'h0, got_v}, 64'h0);
    xfer(1'b0, PG_A + 40'h12, 4'd4, 64'h0);
    chk("R7 misaligned read err", {63'h0, got_e}, 64'h1);
    xfer(1'b1, PG_A + 40'h11, 4'd2, 64'hFFFF);
    chk("R7 misaligned write err", {63'h0, got_e}, 64'h1);
    xfer(1'b1, PG_A + 40'h10, 4'd0, 64'hFFFF);
    chk("R7 size 0 err", {63'h0, got_e}, 64'h1);
    xfer(1'b1, PG_A + 40'h10, 4'd9, 64'hFFFF);
    chk("R7 size 9 err", {63'h0, got_e}, 64'h1);
    rd(PG_A + 40'h10, 4'd8, 64'h1234_0000_AB00_0000, "R7 rejected writes left no trace");
    chk("R7 err pulse ends", {63'h0, got_e}, 64'h0);
  endtask

  task automatic t_reset_again();
    do_reset();
    rd(PG_A + 40'h10, 4'd8, 64'h0, "R8 low page cleared");
    rd(PG_B + 40'h10, 4'd8, 64'h0, "R8 top page cleared");
    wr(PG_C + 40'h0, 4'd8, 64'h5, "R9 write after reset");
    rd(PG_C + 40'h0, 4'd8, 64'h5, "R9 capacity returned");
    wr(PG_A + 40'h8, 4'd8, 64'h9, "R9 second page");
    rd(PG_A + 40'h8, 4'd8, 64'h9, "R9 second page bound");
    wr(PG_B + 40'h8, 4'd8, 64'h7, "R10 third page");
    rd(PG_B + 40'h8, 4'd8, 64'h0, "R10 limit again after reset");
  endtask

  initial begin
    t_reset_state();
    t_dropped_writes();
    t_alloc_zero_fill();
    t_lanes();
    t_alias_and_capacity();
    t_errors();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule